// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core with Switch Register

This block is a 32-bit in-order processor for a small MIPS integer subset: ADD, SUB, SLT, ADDI, LW, SW, BEQ and J. It has five stages: fetch, decode, execute, memory and writeback. Instructions come from an external read port. The fetch address is an output, and the addressed word must be presented on the instruction input within the same cycle. The core holds a 64-word data memory and a register of switch inputs that is reached through memory-mapped I/O.

Conditional branches and jumps are resolved in the decode stage. When one of them is taken, the single slot fetched behind it is discarded. Results are forwarded to the execute stage from the memory and writeback stages, and to a decode-stage BEQ from the memory stage.

The core stalls in two cases. The first is a load-use dependency. The second is a BEQ whose source register is not yet available: it is still being computed in execute, or it is being loaded in the memory stage.

A store to the switch address does not write data memory. Instead it samples the live switch pins into the I/O register, and a load from that address reads the register back.

The retired-result outputs form a valid-qualified stream without a ready signal. Every write to a nonzero register appears on them once, in program order, in the cycle the result sits in writeback. The consumer cannot apply back-pressure and must accept each beat as it arrives.

Top module: `mips5_core`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the fetch PC is 0, no flag is raised, no retired result is valid, and all 32 registers and all data-memory words read as zero.
- R2: The core decodes the standard 32-bit MIPS R, I and J formats with these encodings: opcode 0x00 with funct 0x20 for ADD, 0x22 for SUB and 0x2A for signed SLT; opcode 0x08 for ADDI, 0x23 for LW, 0x2B for SW, 0x04 for BEQ and 0x02 for J. Without stalls or redirects, the fetch PC advances by 4 every cycle.
- R3: A BEQ whose operands are equal raises br_taken for one cycle in the cycle it sits unstalled in decode. The next fetch PC is then PC+4 plus the sign-extended offset shifted left by 2. For example, a BEQ at 0x10 with offset 5 is followed by a fetch from 0x28.
- R4: A BEQ whose operands differ raises br_not_taken for one cycle in its unstalled decode cycle, and the fetch continues sequentially.
- R5: When the instruction in decode reads the destination of an LW in execute, load_stall is raised for that cycle and the fetch PC holds for one extra cycle.
- R6: Back-to-back dependent ALU instructions, and a decode-stage BEQ, see the newest value of a register through forwarding or stalling. Retired values therefore match sequential execution.
- R7: J redirects to {PC+4[31:28], index, 2'b00}. A taken BEQ or a J discards the one instruction fetched behind it.
- R8: A store to 0xFFFFFFF4 leaves data memory unchanged. It loads the 4-bit switch input, zero-extended to 32 bits, into the I/O register and ignores the store data.
- R9: A load from 0xFFFFFFF4 returns the I/O register. Every other address reads and writes data word address[7:2].
- R10: Register 0 always reads as zero, including straight after an instruction that names it as destination.
- R11: The Fibonacci loop program ends with 0xE9 as the last value written to register 16 when the switches are 1101, and with 0x08 when they are 0110.
- R12: The 16-bit LW/SW offset is sign-extended, so an offset of 0xFFF4 from register 0 reaches address 0xFFFFFFF4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc | output | 32 | Current fetch PC, also used as the instruction read address |
| imem_data | input | 32 | Instruction word at fetch_pc, valid in the same cycle |
| sw_in | input | 4 | Live switch inputs |
| load_stall | output | 1 | Load-use stall in this cycle |
| br_taken | output | 1 | A BEQ resolved as taken this cycle |
| br_not_taken | output | 1 | A BEQ resolved as not taken this cycle |
| wb_valid | output | 1 | Retired-result beat is valid |
| wb_reg | output | 5 | Destination register of the beat |
| wb_data | output | 32 | Value written by the beat |

## Verification
A straight-line program is used to pin the cycle timing. It exercises a not-taken BEQ, a taken BEQ with the squashed slot, a store, a load and a load-use pair, and the PC and the flags are compared against a fixed timeline. This separates a redirect from a plain step and shows a missing stall.

An I/O program does several things. It writes register 0 and reads it back at once, it stores to a data word whose index aliases the switch address, and it then stores to the switch address and loads both locations. This separates the two memory paths and shows whether the store data or the pin value was captured.

The Fibonacci loop is run with two switch settings. It mixes a jump, a backward loop, a forwarded branch operand and the I/O load, so a wrong count or a stale operand changes the final value.

// File: rtl/mips5_pkg.sv
package mips5_pkg;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] FN_ADD   = 6'h20;
  localparam logic [5:0] FN_SUB   = 6'h22;
  localparam logic [5:0] FN_SLT   = 6'h2A;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_SLT} alu_op_e;

  typedef struct packed {
    logic       reg_wr;
    logic       mem_rd;
    logic       mem_wr;
    logic       use_imm;
    logic       uses_rs;
    logic       uses_rt;
    logic       is_beq;
    logic       is_j;
    alu_op_e    alu;
    logic [4:0] dst;
  } ctrl_t;

  function automatic ctrl_t decode(input logic [31:0] ins);
    ctrl_t c;
    c = '0;
    c.alu = ALU_ADD;
    case (ins[31:26])
      OP_RTYPE: begin
        c.uses_rs = 1'b1; c.uses_rt = 1'b1; c.dst = ins[15:11]; c.reg_wr = 1'b1;
        case (ins[5:0])
          FN_ADD:  c.alu = ALU_ADD;
          FN_SUB:  c.alu = ALU_SUB;
          FN_SLT:  c.alu = ALU_SLT;
          default: c.reg_wr = 1'b0;
        endcase
      end
      OP_ADDI: begin c.uses_rs = 1'b1; c.use_imm = 1'b1; c.reg_wr = 1'b1; c.dst = ins[20:16]; end
      OP_LW: begin
        c.uses_rs = 1'b1; c.use_imm = 1'b1; c.reg_wr = 1'b1; c.mem_rd = 1'b1; c.dst = ins[20:16];
      end
      OP_SW:  begin c.uses_rs = 1'b1; c.uses_rt = 1'b1; c.use_imm = 1'b1; c.mem_wr = 1'b1; end
      OP_BEQ: begin c.uses_rs = 1'b1; c.uses_rt = 1'b1; c.is_beq = 1'b1; end
      OP_J:   c.is_j = 1'b1;
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/mips5_regfile.sv
module mips5_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(NREG)-1:0] ra_a,
  input  logic [$clog2(NREG)-1:0] ra_b,
  output logic [W-1:0]            rd_a,
  output logic [W-1:0]            rd_b,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] wa,
  input  logic [W-1:0]            wd
);
  localparam int AW = $clog2(NREG);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  // Write-through so a value retiring this cycle is seen by decode.
  always_comb begin
    rd_a = (ra_a == '0) ? '0 : (we && wa == ra_a) ? wd : regs[ra_a];
    rd_b = (ra_b == '0) ? '0 : (we && wa == ra_b) ? wd : regs[ra_b];
  end

  a_r10_zero_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_a == AW'(0)) |-> (rd_a == '0));
endmodule

// File: rtl/mips5_alu.sv
module mips5_alu
  import mips5_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, $signed(a) < $signed(b)};
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/mips5_hazard.sv
module mips5_hazard (
  input  logic [4:0] id_rs,
  input  logic [4:0] id_rt,
  input  logic       id_uses_rs,
  input  logic       id_uses_rt,
  input  logic       id_is_beq,
  input  logic [4:0] ex_rs,
  input  logic [4:0] ex_rt,
  input  logic       ex_reg_wr,
  input  logic       ex_mem_rd,
  input  logic [4:0] ex_dst,
  input  logic       mem_reg_wr,
  input  logic       mem_mem_rd,
  input  logic [4:0] mem_dst,
  input  logic       wb_reg_wr,
  input  logic [4:0] wb_dst,
  output logic       lw_stall,
  output logic       br_stall,
  output logic       id_fwd_a,
  output logic       id_fwd_b,
  output logic [1:0] ex_fwd_a,
  output logic [1:0] ex_fwd_b
);
  logic ex_w, mem_w, wb_w, id_hit_ex, id_hit_mem;
  assign ex_w  = ex_reg_wr  && ex_dst  != 5'd0;
  assign mem_w = mem_reg_wr && mem_dst != 5'd0;
  assign wb_w  = wb_reg_wr  && wb_dst  != 5'd0;

  assign id_hit_ex  = ex_w  && ((id_uses_rs && id_rs == ex_dst)  || (id_uses_rt && id_rt == ex_dst));
  assign id_hit_mem = mem_w && ((id_uses_rs && id_rs == mem_dst) || (id_uses_rt && id_rt == mem_dst));

  assign lw_stall = ex_mem_rd && id_hit_ex;
  assign br_stall = id_is_beq && (id_hit_ex || (mem_mem_rd && id_hit_mem));

  assign id_fwd_a = mem_w && !mem_mem_rd && id_rs == mem_dst;
  assign id_fwd_b = mem_w && !mem_mem_rd && id_rt == mem_dst;

  // 1: from memory stage, 2: from writeback, 0: register value
  always_comb begin
    ex_fwd_a = (mem_w && ex_rs == mem_dst) ? 2'd1 : (wb_w && ex_rs == wb_dst) ? 2'd2 : 2'd0;
    ex_fwd_b = (mem_w && ex_rt == mem_dst) ? 2'd1 : (wb_w && ex_rt == wb_dst) ? 2'd2 : 2'd0;
  end
endmodule

// File: rtl/mips5_dmem_io.sv
module mips5_dmem_io #(
  parameter int          WORDS   = 64,
  parameter int          SW_W    = 4,
  parameter logic [31:0] IO_ADDR = 32'hFFFF_FFF4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     addr,
  input  logic [31:0]     wdata,
  input  logic            we,
  input  logic [SW_W-1:0] sw_in,
  output logic [31:0]     rdata
);
  localparam int IW = $clog2(WORDS);
  logic [31:0]   mem [WORDS];
  logic [31:0]   io_q;
  logic [IW-1:0] idx;
  logic          io_hit;

  assign idx    = addr[IW+1:2];
  assign io_hit = (addr == IO_ADDR);
  assign rdata  = io_hit ? io_q : mem[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      io_q <= '0;
    end else if (we) begin
      if (io_hit) io_q <= {{(32-SW_W){1'b0}}, sw_in};
      else        mem[idx] <= wdata;
    end
  end

  logic [IW-1:0] chk_idx;
  logic [31:0]   chk_word;
  always_ff @(posedge clk) begin
    chk_idx  <= idx;
    chk_word <= mem[idx];
  end

  a_r8_io_store_spares_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (we && io_hit) |=> (mem[chk_idx] == chk_word));
endmodule

// File: rtl/mips5_core.sv
module mips5_core
  import mips5_pkg::*;
#(
  parameter int          DMEM_WORDS = 64,
  parameter int          SW_W       = 4,
  parameter logic [31:0] IO_ADDR    = 32'hFFFF_FFF4
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [31:0]     fetch_pc,
  input  logic [31:0]     imem_data,
  input  logic [SW_W-1:0] sw_in,
  output logic            load_stall,
  output logic            br_taken,
  output logic            br_not_taken,
  output logic            wb_valid,
  output logic [4:0]      wb_reg,
  output logic [31:0]     wb_data
);
  typedef struct packed { logic valid; logic [31:0] pc; logic [31:0] ins; } ifid_t;
  typedef struct packed { ctrl_t c; logic [4:0] rs, rt; logic [31:0] a, b, imm; } idex_t;
  typedef struct packed { logic reg_wr, mem_rd, mem_wr; logic [4:0] dst; logic [31:0] res, sdata; } exmem_t;
  typedef struct packed { logic reg_wr; logic [4:0] dst; logic [31:0] val; } memwb_t;

  logic [31:0] pc_q;
  ifid_t  ifid_q;
  idex_t  idex_q, idex_d;
  exmem_t exmem_q, exmem_d;
  memwb_t memwb_q, memwb_d;

  // ---------------- decode ----------------
  ctrl_t       ctl;
  logic [4:0]  rs, rt;
  logic [31:0] imm, rf_a, rf_b, cmp_a, cmp_b, pc4, tgt;
  logic        lw_stall, br_stall, stall, id_fwd_a, id_fwd_b, eq, redirect;
  logic [1:0]  ex_fwd_a, ex_fwd_b;

  assign ctl = ifid_q.valid ? decode(ifid_q.ins) : '0;
  assign rs  = ifid_q.ins[25:21];
  assign rt  = ifid_q.ins[20:16];
  assign imm = {{16{ifid_q.ins[15]}}, ifid_q.ins[15:0]};
  assign pc4 = ifid_q.pc + 32'd4;

  mips5_regfile #(.NREG(32), .W(32)) u_rf (
    .clk(clk), .rst_n(rst_n), .ra_a(rs), .ra_b(rt), .rd_a(rf_a), .rd_b(rf_b),
    .we(memwb_q.reg_wr), .wa(memwb_q.dst), .wd(memwb_q.val));

  mips5_hazard u_hz (
    .id_rs(rs), .id_rt(rt), .id_uses_rs(ctl.uses_rs), .id_uses_rt(ctl.uses_rt),
    .id_is_beq(ctl.is_beq), .ex_rs(idex_q.rs), .ex_rt(idex_q.rt),
    .ex_reg_wr(idex_q.c.reg_wr), .ex_mem_rd(idex_q.c.mem_rd), .ex_dst(idex_q.c.dst),
    .mem_reg_wr(exmem_q.reg_wr), .mem_mem_rd(exmem_q.mem_rd), .mem_dst(exmem_q.dst),
    .wb_reg_wr(memwb_q.reg_wr), .wb_dst(memwb_q.dst),
    .lw_stall(lw_stall), .br_stall(br_stall), .id_fwd_a(id_fwd_a), .id_fwd_b(id_fwd_b),
    .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b));

  assign stall    = lw_stall || br_stall;
  assign cmp_a    = id_fwd_a ? exmem_q.res : rf_a;
  assign cmp_b    = id_fwd_b ? exmem_q.res : rf_b;
  assign eq       = (cmp_a == cmp_b);
  assign redirect = !stall && ((ctl.is_beq && eq) || ctl.is_j);
  assign tgt      = ctl.is_j ? {pc4[31:28], ifid_q.ins[25:0], 2'b00} : pc4 + {imm[29:0], 2'b00};

  always_comb begin
    idex_d.c   = ctl;
    idex_d.rs  = rs;
    idex_d.rt  = rt;
    idex_d.a   = rf_a;
    idex_d.b   = rf_b;
    idex_d.imm = imm;
  end

  // ---------------- execute ----------------
  logic [31:0] op_a, op_b_reg, alu_y;
  always_comb begin
    case (ex_fwd_a)
      2'd1:    op_a = exmem_q.res;
      2'd2:    op_a = memwb_q.val;
      default: op_a = idex_q.a;
    endcase
    case (ex_fwd_b)
      2'd1:    op_b_reg = exmem_q.res;
      2'd2:    op_b_reg = memwb_q.val;
      default: op_b_reg = idex_q.b;
    endcase
  end

  mips5_alu #(.W(32)) u_alu (
    .a(op_a), .b(idex_q.c.use_imm ? idex_q.imm : op_b_reg), .op(idex_q.c.alu), .y(alu_y));

  always_comb begin
    exmem_d.reg_wr = idex_q.c.reg_wr;
    exmem_d.mem_rd = idex_q.c.mem_rd;
    exmem_d.mem_wr = idex_q.c.mem_wr;
    exmem_d.dst    = idex_q.c.dst;
    exmem_d.res    = alu_y;
    exmem_d.sdata  = op_b_reg;
  end

  // ---------------- memory ----------------
  logic [31:0] rdata;
  mips5_dmem_io #(.WORDS(DMEM_WORDS), .SW_W(SW_W), .IO_ADDR(IO_ADDR)) u_mem (
    .clk(clk), .rst_n(rst_n), .addr(exmem_q.res), .wdata(exmem_q.sdata),
    .we(exmem_q.mem_wr), .sw_in(sw_in), .rdata(rdata));

  always_comb begin
    memwb_d.reg_wr = exmem_q.reg_wr;
    memwb_d.dst    = exmem_q.dst;
    memwb_d.val    = exmem_q.mem_rd ? rdata : exmem_q.res;
  end

  // ---------------- pipeline registers ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= '0; ifid_q <= '0; idex_q <= '0; exmem_q <= '0; memwb_q <= '0;
    end else begin
      if (!stall) begin
        pc_q         <= redirect ? tgt : pc_q + 32'd4;
        ifid_q.valid <= !redirect;
        ifid_q.pc    <= pc_q;
        ifid_q.ins   <= imem_data;
      end
      idex_q  <= stall ? '0 : idex_d;
      exmem_q <= exmem_d;
      memwb_q <= memwb_d;
    end
  end

  assign fetch_pc     = pc_q;
  assign load_stall   = lw_stall;
  assign br_taken     = ctl.is_beq && !stall && eq;
  assign br_not_taken = ctl.is_beq && !stall && !eq;
  assign wb_valid     = memwb_q.reg_wr && memwb_q.dst != 5'd0;
  assign wb_reg       = memwb_q.dst;
  assign wb_data      = memwb_q.val;

  a_r5_stall_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
    load_stall |=> $stable(fetch_pc));
  a_r7_slot_squashed: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !ifid_q.valid);
  a_r2_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_pc[1:0] == 2'b00);
endmodule

// File: tb/mips5_core_tb.sv
module mips5_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc, imem_data, wb_data;
  logic [3:0]  sw_in = 4'd0;
  logic        load_stall, br_taken, br_not_taken, wb_valid;
  logic [4:0]  wb_reg;
  logic [31:0] imem [64];

  int checks = 0, fails = 0, cyc = 0;
  logic [36:0] exp_q [$];
  logic [31:0] last_s0;

  always #4 clk = ~clk;
  assign imem_data = imem[fetch_pc[7:2]];

  mips5_core u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .imem_data(imem_data), .sw_in(sw_in),
    .load_stall(load_stall), .br_taken(br_taken), .br_not_taken(br_not_taken),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected <150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic logic [31:0] rins(input int rs_, input int rt_, input int rd_, input logic [5:0] fn);
    return {6'h00, 5'(rs_), 5'(rt_), 5'(rd_), 5'd0, fn};
  endfunction
  function automatic logic [31:0] iins(input logic [5:0] op, input int rs_, input int rt_, input logic [15:0] im);
    return {op, 5'(rs_), 5'(rt_), im};
  endfunction
  function automatic logic [31:0] jins(input int idx);
    return {6'h02, 26'(idx)};
  endfunction

  // Sequential reference: in-order list of nonzero register writes.
  task automatic model(input logic [3:0] swv);
    logic [31:0] r [32];
    logic [31:0] m [64];
    logic [31:0] io, pc, ins, a, b, im, v, ad;
    int rd;
    bit wr;
    for (int i = 0; i < 32; i++) r[i] = '0;
    for (int i = 0; i < 64; i++) m[i] = '0;
    io = '0; pc = '0;
    exp_q.delete();
    for (int s = 0; s < 4000; s++) begin
      ins = imem[pc[7:2]];
      a = r[ins[25:21]]; b = r[ins[20:16]];
      im = {{16{ins[15]}}, ins[15:0]};
      wr = 1'b0; rd = 0; v = '0;
      case (ins[31:26])
        6'h00: begin
          rd = int'(ins[15:11]); wr = 1'b1;
          if (ins[5:0] == 6'h20) v = a + b;
          else if (ins[5:0] == 6'h22) v = a - b;
          else if (ins[5:0] == 6'h2A) v = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          else wr = 1'b0;
          pc = pc + 4;
        end
        6'h08: begin rd = int'(ins[20:16]); wr = 1'b1; v = a + im; pc = pc + 4; end
        6'h23: begin
          ad = a + im; rd = int'(ins[20:16]); wr = 1'b1;
          v = (ad == 32'hFFFF_FFF4) ? io : m[ad[7:2]]; pc = pc + 4;
        end
        6'h2B: begin
          ad = a + im;
          if (ad == 32'hFFFF_FFF4) io = {28'd0, swv}; else m[ad[7:2]] = b;
          pc = pc + 4;
        end
        6'h04: pc = (a == b) ? pc + 4 + {im[29:0], 2'b00} : pc + 4;
        6'h02: begin
          v = {pc[31:28] , ins[25:0], 2'b00};
          if (v == pc) break;
          pc = v;
        end
        default: pc = pc + 4;
      endcase
      if (wr && rd != 0) begin
        r[rd] = v;
        exp_q.push_back({5'(rd), v});
      end
    end
  endtask

  // Runs the loaded program; tm enables the fixed timeline of the straight-line program.
  task automatic run(input logic [3:0] swv, input int ncyc, input bit tm, input string req);
    int exp_pc [13] = '{32'h00, 32'h04, 32'h08, 32'h0C, 32'h10, 32'h14, 32'h28,
                        32'h2C, 32'h30, 32'h34, 32'h38, 32'h38, 32'h3C};
    model(swv);
    sw_in = swv;
    last_s0 = '0;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(fetch_pc == 0, "R1 pc in reset", fetch_pc, 0);
    chk(!wb_valid && !load_stall && !br_taken && !br_not_taken, "R1 quiet in reset",
        {wb_valid, load_stall, br_taken, br_not_taken}, 0);
    rst_n = 1'b1;
    #1;
    for (int c = 0; c < ncyc; c++) begin
      if (wb_valid) begin
        if (exp_q.size() == 0) chk(1'b0, {req, " R6 unexpected write"}, {27'd0, wb_reg}, 0);
        else begin
          chk({wb_reg, wb_data} == exp_q[0], {req, " R6 retired write"}, wb_data, exp_q[0][31:0]);
          void'(exp_q.pop_front());
        end
        if (wb_reg == 5'd16) last_s0 = wb_data;
      end
      if (tm && c < 13) begin
        chk(fetch_pc == exp_pc[c], (c == 6) ? "R3 branch target" : (c == 11) ? "R5 pc held" :
            "R2 pc step", fetch_pc, exp_pc[c]);
        chk(br_not_taken == (c == 4), "R4 not-taken flag", {31'd0, br_not_taken}, {31'd0, c == 4});
        chk(br_taken == (c == 5), "R3 taken flag", {31'd0, br_taken}, {31'd0, c == 5});
        chk(load_stall == (c == 10), "R5 stall flag", {31'd0, load_stall}, {31'd0, c == 10});
      end
      @(negedge clk); #1;
    end
    chk(exp_q.size() == 0, {req, " all writes retired"}, exp_q.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) imem[i] = '0;
    // Straight-line program: R2 R3 R4 R5 R7
    imem[0]  = iins(6'h08, 0, 8, 16'd1);
    imem[1]  = iins(6'h08, 0, 18, 16'd2);
    imem[2]  = rins(18, 8, 9, 6'h22);
    imem[3]  = iins(6'h04, 8, 18, 16'd4);
    imem[4]  = iins(6'h04, 8, 9, 16'd5);
    for (int i = 5; i < 10; i++) imem[i] = iins(6'h08, 16, 16, 16'd1);
    imem[10] = iins(6'h2B, 0, 18, 16'd8);
    imem[11] = rins(8, 18, 17, 6'h2A);
    imem[12] = iins(6'h23, 0, 19, 16'd8);
    imem[13] = rins(19, 17, 20, 6'h20);
    imem[14] = jins(14);
    run(4'd0, 40, 1'b1, "R7 prog A");

    // I/O and zero register: R8 R9 R10 R12
    for (int i = 0; i < 64; i++) imem[i] = '0;
    imem[0] = iins(6'h08, 0, 0, 16'd5);
    imem[1] = rins(0, 0, 12, 6'h20);
    imem[2] = iins(6'h08, 0, 8, 16'h55);
    imem[3] = iins(6'h2B, 0, 8, 16'h00F4);
    imem[4] = iins(6'h2B, 0, 8, 16'hFFF4);
    imem[5] = iins(6'h23, 0, 9, 16'h00F4);
    imem[6] = iins(6'h23, 0, 10, 16'hFFF4);
    imem[7] = rins(10, 9, 11, 6'h20);
    imem[8] = jins(8);
    run(4'd9, 30, 1'b0, "R8 R9 R10 R12 prog C");

    // Fibonacci loop: R11
    for (int i = 0; i < 64; i++) imem[i] = '0;
    imem[0]  = iins(6'h2B, 0, 0, 16'hFFF4);
    imem[1]  = iins(6'h08, 0, 9, 16'd2);
    imem[2]  = iins(6'h23, 0, 8, 16'hFFF4);
    imem[3]  = iins(6'h08, 0, 16, 16'd1);
    imem[4]  = iins(6'h08, 0, 17, 16'd1);
    imem[5]  = iins(6'h04, 9, 8, 16'd6);
    imem[6]  = rins(16, 0, 10, 6'h20);
    imem[7]  = rins(16, 17, 16, 6'h20);
    imem[8]  = rins(10, 0, 17, 6'h20);
    imem[9]  = iins(6'h08, 9, 9, 16'd1);
    imem[10] = jins(5);
    imem[11] = iins(6'h08, 0, 11, 16'd8);
    imem[12] = jins(12);
    run(4'b1101, 400, 1'b0, "R11 fibo 13");
    chk(last_s0 == 32'hE9, "R11 final s0 n=13", last_s0, 32'hE9);
    run(4'b0110, 400, 1'b0, "R11 fibo 6");
    chk(last_s0 == 32'h08, "R11 final s0 n=6", last_s0, 32'h08);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule